// File: doc/BRIEF.md
# Tagged bimodal branch direction predictor

This block predicts whether a conditional branch will be taken. It keeps a direct-mapped table of 2-bit saturating direction counters. The low-order bits of the branch address select a slot. Each slot also holds the address bits above the index as a tag, plus a valid bit. A prediction is used only when the slot is valid and its tag equals the upper bits of the lookup address. A different branch that happens to map to the same slot therefore cannot steer the outcome.

The front end presents a branch address on the lookup port and receives a direction and a hit flag in the same cycle, read from the registered table. When the branch resolves, the back end presents its address and actual outcome on the update port. A matching entry is trained one step toward that outcome. A missing or foreign entry is replaced by a fresh one. Software or the pipeline raises the flush input on a context switch, or before running untrusted code, and this discards everything the table has learned in one cycle.

The table depth and the address width are parameters. The tag width is the address width minus the index width. A 32-bit address with a 14-bit index gives an 18-bit tag and a 20-bit entry. A 48-bit address with a 14-bit index gives a 34-bit tag. The default index width is kept at 10 bits so that elaboration stays small, and it can be raised to 14.

Top module: `tagged_bimodal_bp`

## Requirements
- R1: After a synchronous reset every slot is invalid, so every lookup returns lk_hit=0 and lk_taken=0.
- R2: A lookup that misses (slot invalid, or stored tag differs from lk_addr[ADDR_W-1:IDX_W]) returns lk_hit=0 and lk_taken=0 (not-taken).
- R3: An update that misses allocates the slot: it stores the new tag, sets valid and loads weakly taken (2'b10) if up_taken=1 or weakly not-taken (2'b01) if up_taken=0. A lookup of that address in the next cycle hits and predicts the update's outcome.
- R4: An update that hits moves the counter one step toward the outcome. The counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken, and the prediction is counter bit 1.
- R5: The counter saturates: a taken update at 11 stays at 11, and a not-taken update at 00 stays at 00.
- R6: The tag is every address bit above the index. Two addresses with the same low IDX_W bits but any differing upper bit do not share a prediction.
- R7: An update from an aliasing address replaces the slot, after which the previous owner's address misses.
- R8: Asserting flush for one cycle invalidates every slot by the next cycle.
- R9: When flush and up_en are high in the same cycle, the flush wins and the updated address misses afterwards.
- R10: A lookup and an update to the same slot in the same cycle return the state from before the update. The new state is visible from the next cycle.
- R11: With no update, flush or reset, the table holds its contents, so a steady lookup address gives a steady result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, invalidates all slots |
| flush | input | 1 | Invalidate the whole table at the next edge |
| lk_addr | input | ADDR_W | Branch address to predict |
| lk_hit | output | 1 | Slot valid and tag matches |
| lk_taken | output | 1 | Predicted direction, 0 on a miss |
| up_en | input | 1 | Resolved-branch update strobe |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The lookup result is combinational from the table, so a new lk_addr is checked one time unit after it is driven, in the same cycle. An update, flush or reset takes effect at the next rising edge. Its result is checked on the lookup port after the following falling edge, which is exactly one cycle later. The same-cycle case drives the update and the lookup together and samples before the edge to see the old state, then samples again after the edge to see the new one. All stimulus changes on falling edges, so no sample lands on the active edge.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_t;

  localparam int CTR_W = 2;

  // one saturating step toward the outcome
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      default: nxt = taken ? CTR_ST  : CTR_WT;
    endcase
    return nxt;
  endfunction

  // initial state of a freshly allocated slot
  function automatic ctr_t ctr_seed(input logic taken);
    return taken ? CTR_WT : CTR_WNT;
  endfunction

endpackage

// File: rtl/tbp_valid_vec.sv
module tbp_valid_vec #(
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic             rd_a,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic             rd_b
);

  // valid bits live in flops so that a whole-table clear takes one cycle
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
    end else if (set_en) begin
      vld_q[set_idx] <= 1'b1;
    end
  end

  assign rd_a = vld_q[rd_a_idx];
  assign rd_b = vld_q[rd_b_idx];

endmodule

// File: rtl/tbp_entry_ram.sv
module tbp_entry_ram #(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 24,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  // tag and counter storage, no reset, one write port, two async reads
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/tbp_train.sv
module tbp_train
  import tbp_pkg::*;
#(
  parameter int TAG_W = 22
) (
  input  logic             slot_vld,
  input  logic [TAG_W-1:0] slot_tag,
  input  ctr_t             slot_ctr,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             upd_taken,
  output logic [TAG_W-1:0] new_tag,
  output ctr_t             new_ctr
);

  logic own;

  always_comb begin
    own     = slot_vld && (slot_tag == upd_tag);
    new_tag = upd_tag;
    new_ctr = own ? ctr_step(slot_ctr, upd_taken) : ctr_seed(upd_taken);
  end

endmodule

// File: rtl/tagged_bimodal_bp.sv
module tagged_bimodal_bp
  import tbp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_taken,
  input  logic              up_en,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken
);

  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam int ENTRY_W = TAG_W + CTR_W;

  logic [IDX_W-1:0]   lk_idx, up_idx;
  logic [TAG_W-1:0]   lk_tag, up_tag;
  logic               lk_vld, up_vld;
  logic [ENTRY_W-1:0] lk_ent, up_ent, wr_ent;
  logic [TAG_W-1:0]   wr_tag;
  ctr_t               wr_ctr;
  logic               wr_en;

  assign lk_idx = lk_addr[IDX_W-1:0];
  assign lk_tag = lk_addr[ADDR_W-1:IDX_W];
  assign up_idx = up_addr[IDX_W-1:0];
  assign up_tag = up_addr[ADDR_W-1:IDX_W];

  // flush takes priority over a same-cycle update
  assign wr_en = up_en && !flush && !rst;

  tbp_valid_vec #(.IDX_W(IDX_W)) u_vld (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .set_en   (wr_en),
    .set_idx  (up_idx),
    .rd_a_idx (lk_idx),
    .rd_a     (lk_vld),
    .rd_b_idx (up_idx),
    .rd_b     (up_vld)
  );

  tbp_entry_ram #(.IDX_W(IDX_W), .DATA_W(ENTRY_W)) u_ram (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (up_idx),
    .wdata   (wr_ent),
    .raddr_a (lk_idx),
    .rdata_a (lk_ent),
    .raddr_b (up_idx),
    .rdata_b (up_ent)
  );

  tbp_train #(.TAG_W(TAG_W)) u_train (
    .slot_vld  (up_vld),
    .slot_tag  (up_ent[ENTRY_W-1:CTR_W]),
    .slot_ctr  (ctr_t'(up_ent[CTR_W-1:0])),
    .upd_tag   (up_tag),
    .upd_taken (up_taken),
    .new_tag   (wr_tag),
    .new_ctr   (wr_ctr)
  );

  assign wr_ent = {wr_tag, wr_ctr};

  always_comb begin
    lk_hit   = lk_vld && (lk_ent[ENTRY_W-1:CTR_W] == lk_tag);
    lk_taken = lk_hit && lk_ent[CTR_W-1];
  end

endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic              lk_taken,
  input logic              up_en,
  input logic [ADDR_W-1:0] up_addr,
  input logic              up_taken
);

  // R1: the cycle after reset nothing hits
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);

  // R2: a miss always predicts not-taken
  p_miss_not_taken_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> !lk_taken);

  // R3: an accepted update makes its own address hit next cycle
  p_update_allocates_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(up_en) && !$past(flush) && !$past(rst) && lk_addr == $past(up_addr))
    |-> lk_hit);

  // R8, R9: after a flush the table is empty, even with a same-cycle update
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> !lk_hit);

  // R11: without an update, flush or reset the lookup result holds
  p_idle_holds_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(up_en) && !$past(flush) && $stable(lk_addr))
    |-> ($stable(lk_hit) && $stable(lk_taken)));

endmodule

bind tagged_bimodal_bp tbp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .flush    (flush),
  .lk_addr  (lk_addr),
  .lk_hit   (lk_hit),
  .lk_taken (lk_taken),
  .up_en    (up_en),
  .up_addr  (up_addr),
  .up_taken (up_taken)
);

// File: tb/tb_tagged_bimodal_bp.sv
`timescale 1ns/1ps
module tb_tagged_bimodal_bp;

  localparam int ADDR_W = 32;
  localparam int IDX_W  = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              flush = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic              lk_hit, lk_taken;
  logic              up_en = 1'b0;
  logic [ADDR_W-1:0] up_addr = '0;
  logic              up_taken = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  localparam logic [ADDR_W-1:0] A  = 32'h0000_1234;
  localparam logic [ADDR_W-1:0] AL = A + (32'h1 << IDX_W);  // same slot, other tag
  localparam logic [ADDR_W-1:0] AH = A ^ 32'h8000_0000;     // differs in top bit only
  localparam logic [ADDR_W-1:0] C  = 32'h0000_0ABC;
  localparam logic [ADDR_W-1:0] D  = 32'h0040_0011;

  always #5 clk = ~clk;

  tagged_bimodal_bp #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .up_en(up_en), .up_addr(up_addr), .up_taken(up_taken)
  );

  task automatic expect_lk(input logic [ADDR_W-1:0] a, input logic eh,
                           input logic et, input string req);
    lk_addr = a;
    #1;
    n_checks++;
    if (lk_hit !== eh || lk_taken !== et) begin
      n_fails++;
      $display("FAIL %s addr=%h hit/taken actual=%b%b expected=%b%b",
               req, a, lk_hit, lk_taken, eh, et);
    end
  endtask

  task automatic update(input logic [ADDR_W-1:0] a, input logic t);
    up_en = 1'b1; up_addr = a; up_taken = t;
    @(negedge clk);
    up_en = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    expect_lk(A, 0, 0, "R1");
    expect_lk(C, 0, 0, "R1");
    expect_lk('0, 0, 0, "R1");
  endtask

  task automatic t_alloc();
    update(A, 1'b1);
    expect_lk(A, 1, 1, "R3");   // weak taken
    update(C, 1'b0);
    expect_lk(C, 1, 0, "R3");   // weak not-taken
    expect_lk(D, 0, 0, "R2");   // untouched slot misses
  endtask

  task automatic t_step();
    update(A, 1'b0);            // WT -> WNT
    expect_lk(A, 1, 0, "R4");
    update(A, 1'b1);            // WNT -> WT
    expect_lk(A, 1, 1, "R4");
  endtask

  task automatic t_saturate();
    update(A, 1'b1); update(A, 1'b1); update(A, 1'b1);  // at ST
    update(A, 1'b0);                                    // ST -> WT
    expect_lk(A, 1, 1, "R5");
    update(A, 1'b0);                                    // WT -> WNT
    expect_lk(A, 1, 0, "R5");
    update(C, 1'b0); update(C, 1'b0); update(C, 1'b0);  // at SNT
    update(C, 1'b1);                                    // SNT -> WNT
    expect_lk(C, 1, 0, "R5");
  endtask

  task automatic t_alias();
    update(A, 1'b1); update(A, 1'b1);   // A strong taken
    expect_lk(AL, 0, 0, "R6");
    expect_lk(AH, 0, 0, "R6");
    update(AL, 1'b0);                   // replaces slot
    expect_lk(AL, 1, 0, "R7");
    expect_lk(A, 0, 0, "R7");
  endtask

  task automatic t_same_cycle();
    update(A, 1'b1);                    // A fresh weak taken
    lk_addr = A;
    up_en = 1'b1; up_addr = A; up_taken = 1'b0;
    #1;
    n_checks++;
    if (lk_hit !== 1'b1 || lk_taken !== 1'b1) begin
      n_fails++;
      $display("FAIL R10 old state actual=%b%b expected=11", lk_hit, lk_taken);
    end
    @(negedge clk);
    up_en = 1'b0;
    expect_lk(A, 1, 0, "R10");          // new state next cycle
  endtask

  task automatic t_hold();
    lk_addr = C;
    repeat (3) @(negedge clk);
    expect_lk(C, 1, 0, "R11");
    expect_lk(A, 1, 0, "R11");
  endtask

  task automatic t_flush();
    update(D, 1'b1);
    expect_lk(D, 1, 1, "R8");
    do_flush();
    expect_lk(A, 0, 0, "R8");
    expect_lk(C, 0, 0, "R8");
    expect_lk(D, 0, 0, "R8");
  endtask

  task automatic t_flush_vs_update();
    update(C, 1'b1);
    flush = 1'b1; up_en = 1'b1; up_addr = A; up_taken = 1'b1;
    @(negedge clk);
    flush = 1'b0; up_en = 1'b0;
    expect_lk(A, 0, 0, "R9");
    expect_lk(C, 0, 0, "R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_alloc();
    t_step();
    t_saturate();
    t_alias();
    t_same_cycle();
    t_hold();
    t_flush();
    t_flush_vs_update();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule